// File: doc/BRIEF.md
# Clock Loss-of-Signal Detector

This block watches a reference clock and raises an alarm when its pulses stop. The reference can come from one of several frequency ranges. A prescaler, set by a 3-bit range code, first divides it down to one common rate of about 19 MHz. That divided signal is then carried into a faster sampling-clock domain, where a short run-length check looks for the reference going flat.

The sampling clock runs at roughly four times the divided rate. A healthy divided signal therefore changes level every two or three samples. When four samples in a row hold the same level, either all high or all low, the block declares loss of signal. It then raises a level alarm and, at the same moment, a hold request that tells a downstream loop to freeze its state. Both outputs fall again on the first sample that differs from the one before it.

Top module: `clk_los_monitor`

## Requirements
- R1: The range code sets the prescale ratio as follows:
  - code 3'b001 divides by 1, code 3'b010 by 2, code 3'b011 by 4, code 3'b100 by 8 and code 3'b101 by 32.
  - code 3'b000 passes the reference through undivided, and the undefined codes 3'b110 and 3'b111 behave exactly like 3'b000.
- R2: The divided signal passes through a two-flop synchronizer clocked by the sampling clock. Every sampling-clock edge then takes one new sample and evaluates it.
- R3: Loss is declared, with `los_alarm` high in the cycle after the sample that completes the run, once four consecutive samples are equal (1111 or 0000).
- R4: A run of three equal samples followed by a different sample never raises the alarm, because any change restarts the run count at one.
- R5: Once declared, `los_alarm` falls in the cycle after the first sample that differs from the previous sample.
- R6: `hold_req` is registered and equals `los_alarm` in every cycle.
- R7: A synchronous reset clears the prescaler, the synchronizer, the run count and both outputs. With a static reference, the outputs stay low through the first three sampling edges after reset and go high after the fourth.
- R8: The run count saturates, so the alarm stays high for as long as the reference stays static.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Reference clock being monitored |
| range_sel | input | 3 | Input-range code that selects the prescale ratio |
| clk_smp | input | 1 | Sampling clock, about 4x the divided rate |
| rst | input | 1 | Synchronous active-high reset |
| los_alarm | output | 1 | Level alarm, high while loss is declared |
| hold_req | output | 1 | Request for the downstream loop to freeze |

## Verification
The bench feeds reference clocks aligned so that each divided half-period spans exactly three samples, then exactly four. A run counter that fails to restart on a change would alarm on the three-sample pattern. A threshold that is off by one would either miss the four-sample pattern or pulse at the wrong rate.

It sweeps every range code against reference rates matched to each ratio. Each combination is expected to stay quiet when the divided half-period is below three samples and to alarm when it reaches five samples, so a wrong divide ratio or a mishandled undefined code shows up as a false or missing alarm.

Further tests stop the reference right at reset release. This catches an alarm that fires early, a counter that wraps and drops the alarm during a long outage, and an alarm that sticks after pulses return.

// File: rtl/clk_los_pkg.sv
`timescale 1ns/1ps
package clk_los_pkg;

    localparam int SEL_W     = 3;
    localparam int MAX_RATIO = 32;
    localparam int RUN_LEN   = 4;
    localparam int SYNC_LEN  = 2;

    typedef enum logic [SEL_W-1:0] {
        RNG_RAW  = 3'b000,
        RNG_X1   = 3'b001,
        RNG_X2   = 3'b010,
        RNG_X4   = 3'b011,
        RNG_X8   = 3'b100,
        RNG_X32  = 3'b101
    } range_e;

    typedef struct packed {
        logic alarm;
        logic hold;
    } los_flags_t;

    // Divide ratio for a range code; undefined codes fall back to raw.
    function automatic int unsigned ratio_of(logic [SEL_W-1:0] code);
        case (range_e'(code))
            RNG_X1:  return 1;
            RNG_X2:  return 2;
            RNG_X4:  return 4;
            RNG_X8:  return 8;
            RNG_X32: return 32;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/los_prescaler.sv
`timescale 1ns/1ps
module los_prescaler
    import clk_los_pkg::*;
#(
    parameter int MAX_DIV = MAX_RATIO
) (
    input  logic             clk_in,
    input  logic             rst,
    input  logic [SEL_W-1:0] range_sel,
    output logic             div_o
);
    localparam int CNT_W = (MAX_DIV / 2 > 1) ? $clog2(MAX_DIV / 2) : 1;

    int unsigned      ratio;
    logic             bypass;
    logic [CNT_W-1:0] last_cnt;
    logic [CNT_W-1:0] cnt_q;
    logic             tog_q;

    always_comb begin
        ratio    = ratio_of(range_sel);
        bypass   = (ratio < 2);
        last_cnt = bypass ? '0 : CNT_W'(ratio / 2 - 1);
    end

    // Toggle every ratio/2 reference edges gives a divide by ratio.
    always_ff @(posedge clk_in) begin
        if (rst) begin
            cnt_q <= '0;
            tog_q <= 1'b0;
        end else if (bypass) begin
            cnt_q <= '0;
            tog_q <= 1'b0;
        end else if (cnt_q >= last_cnt) begin
            cnt_q <= '0;
            tog_q <= ~tog_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb div_o = bypass ? clk_in : tog_q;

    // R1: between terminal counts the divided level holds
    assert_div_hold_R1: assert property (@(posedge clk_in) disable iff (rst)
        (!bypass && $stable(range_sel) && cnt_q < last_cnt) |=> tog_q == $past(tog_q));

    // R1: the raw and undefined codes keep the divider parked
    assert_bypass_idle_R1: assert property (@(posedge clk_in) disable iff (rst)
        (bypass && $stable(range_sel)) |=> (cnt_q == '0 && !tog_q));

endmodule

// File: rtl/los_sync.sv
`timescale 1ns/1ps
module los_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                st_q[i] <= st_q[i-1];
            end
        end
    end

    assign q_o = st_q[STAGES-1];

    for (genvar g = 1; g < STAGES; g++) begin : g_chk
        // R2: each stage carries the previous stage one cycle later
        assert_stage_shift_R2: assert property (@(posedge clk) disable iff (rst)
            $past(!rst) |-> st_q[g] == $past(st_q[g-1]));
    end

endmodule

// File: rtl/los_run_detect.sv
`timescale 1ns/1ps
module los_run_detect
    import clk_los_pkg::*;
#(
    parameter int RUN = RUN_LEN
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       smp_i,
    output los_flags_t flags_o
);
    localparam int             RUN_W   = $clog2(RUN + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN);

    logic             prev_q;
    logic             seen_q;
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_d;
    logic             declare;
    los_flags_t       flags_q;
    logic [RUN_W-1:0] age_q;

    always_comb begin
        if (!seen_q || smp_i != prev_q) begin
            run_d = RUN_W'(1);
        end else if (run_q == RUN_MAX) begin
            run_d = run_q;
        end else begin
            run_d = run_q + 1'b1;
        end
        declare = (run_d == RUN_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            seen_q  <= 1'b0;
            run_q   <= '0;
            flags_q <= '0;
        end else begin
            prev_q  <= smp_i;
            seen_q  <= 1'b1;
            run_q   <= run_d;
            flags_q <= '{alarm: declare, hold: declare};
        end
    end

    assign flags_o = flags_q;

    // Edges since reset, saturating; used only by the checks below.
    always_ff @(posedge clk) begin
        if (rst) age_q <= '0;
        else if (age_q != RUN_MAX) age_q <= age_q + 1'b1;
    end

    // R7: no alarm before RUN samples have been taken
    assert_no_early_alarm_R7: assert property (@(posedge clk) disable iff (rst)
        (age_q < RUN_MAX) |-> !flags_q.alarm);

    // R4: a sample differing from the last one never declares
    assert_change_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (seen_q && smp_i != prev_q) |=> !flags_q.alarm);

    // R5: a declared alarm drops after the first differing sample
    assert_clear_on_edge_R5: assert property (@(posedge clk) disable iff (rst)
        (flags_q.alarm && smp_i != prev_q) |=> !flags_q.alarm);

    // R6: hold request tracks alarm
    assert_hold_tracks_R6: assert property (@(posedge clk) disable iff (rst)
        flags_q.hold == flags_q.alarm);

    // R8: alarm persists while samples stay equal
    assert_alarm_sticks_R8: assert property (@(posedge clk) disable iff (rst)
        (flags_q.alarm && smp_i == prev_q) |=> flags_q.alarm);

    if (RUN == 4) begin : g_run4
        // R3: four equal samples in a row declare loss
        assert_declare_run_R3: assert property (@(posedge clk) disable iff (rst)
            (age_q >= RUN_W'(3) && smp_i == prev_q && $past(smp_i == prev_q)
             && $past(smp_i == prev_q, 2)) |=> flags_q.alarm);
    end

endmodule

// File: rtl/clk_los_monitor.sv
`timescale 1ns/1ps
module clk_los_monitor
    import clk_los_pkg::*;
#(
    parameter int MAX_DIV   = MAX_RATIO,
    parameter int SYNC_DEPTH = SYNC_LEN,
    parameter int RUN       = RUN_LEN
) (
    input  logic             clk_in,
    input  logic [SEL_W-1:0] range_sel,
    input  logic             clk_smp,
    input  logic             rst,
    output logic             los_alarm,
    output logic             hold_req
);
    logic       div_sig;
    logic       smp_sig;
    los_flags_t flags;

    los_prescaler #(.MAX_DIV(MAX_DIV)) u_prescale (
        .clk_in    (clk_in),
        .rst       (rst),
        .range_sel (range_sel),
        .div_o     (div_sig)
    );

    los_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk_smp),
        .rst (rst),
        .d_i (div_sig),
        .q_o (smp_sig)
    );

    los_run_detect #(.RUN(RUN)) u_detect (
        .clk     (clk_smp),
        .rst     (rst),
        .smp_i   (smp_sig),
        .flags_o (flags)
    );

    assign los_alarm = flags.alarm;
    assign hold_req  = flags.hold;

endmodule

// File: tb/test_clk_los_monitor.sv
`timescale 1ns/1ps
module test_clk_los_monitor;

    logic       clk_smp   = 1'b0;
    logic       clk_in    = 1'b0;
    logic       rst       = 1'b1;
    logic [2:0] range_sel = 3'b001;
    logic       los_alarm;
    logic       hold_req;

    real in_half = 25.0;
    bit  in_run  = 1'b0;

    int checks = 0;
    int errors = 0;
    int hold_mism = 0;

    clk_los_monitor i_clk_los_monitor (
        .clk_in    (clk_in),
        .range_sel (range_sel),
        .clk_smp   (clk_smp),
        .rst       (rst),
        .los_alarm (los_alarm),
        .hold_req  (hold_req)
    );

    always #10 clk_smp = ~clk_smp;   // 50 MHz sampling clock

    initial begin
        forever begin
            wait (in_run);
            while (in_run) begin
                #(in_half) clk_in = ~clk_in;
            end
            clk_in = 1'b0;
        end
    end

    always @(negedge clk_smp) if (!rst && hold_req !== los_alarm) hold_mism++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    function automatic int ratio_for(input int code);
        case (code)
            1: return 1;
            2: return 2;
            3: return 4;
            4: return 8;
            5: return 32;
            default: return 1;
        endcase
    endfunction

    // Reset with the reference running; optionally stop it before release.
    task automatic do_reset(input bit keep_running);
        rst    = 1'b1;
        in_run = 1'b1;
        repeat (20) @(posedge clk_smp);
        if (!keep_running) begin
            in_run = 1'b0;
            #(in_half + 2.0);
        end
        @(negedge clk_smp);
        rst = 1'b0;
    endtask

    // Watch for n cycles; count high samples and rising edges of the alarm.
    task automatic watch(input int n, output int highs, output int rises);
        bit last;
        highs = 0;
        rises = 0;
        last  = los_alarm;
        for (int k = 0; k < n; k++) begin
            @(negedge clk_smp);
            if (los_alarm) highs++;
            if (los_alarm && !last) rises++;
            last = los_alarm;
        end
    endtask

    initial begin
        #(150000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int highs, rises, early;

        // R7: reset state, then a static reference from reset release
        range_sel = 3'b001;
        in_half   = 25.0;
        do_reset(1'b0);
        check(los_alarm === 1'b0 && hold_req === 1'b0, "R7 reset state",
              int'(los_alarm), 0);
        early = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk_smp);
            if (los_alarm !== 1'b0) early++;
        end
        check(early == 0, "R7 low for first three samples", early, 0);
        @(negedge clk_smp);
        check(los_alarm === 1'b1, "R7 high after fourth sample", int'(los_alarm), 1);

        // R8: alarm holds through a long outage
        watch(100, highs, rises);
        check(highs == 100, "R8 alarm held while static", highs, 100);

        // R5: pulses return, alarm clears
        in_run = 1'b1;
        repeat (10) @(negedge clk_smp);
        check(los_alarm === 1'b0, "R5 clear after edges return", int'(los_alarm), 0);

        // R4: divided half-period of exactly three samples
        range_sel = 3'b001;
        in_half   = 60.0;
        do_reset(1'b0);
        @(posedge clk_smp);
        #5;
        in_run = 1'b1;
        repeat (30) @(negedge clk_smp);
        watch(200, highs, rises);
        check(highs == 0, "R4 three-sample runs stay quiet", highs, 0);

        // R3: divided half-period of exactly four samples: one pulse per half
        in_half = 80.0;
        do_reset(1'b0);
        @(posedge clk_smp);
        #5;
        in_run = 1'b1;
        repeat (30) @(negedge clk_smp);
        watch(200, highs, rises);
        check(rises >= 48 && rises <= 51, "R3 four-sample runs declare", rises, 50);
        check(highs == rises, "R3 R5 one-cycle alarm per run", highs, rises);

        // R1: every code against every matched reference rate
        for (int code = 0; code < 8; code++) begin
            for (int ri = 0; ri < 5; ri++) begin
                int rr, rc;
                rr = ratio_for(ri + 1);
                rc = ratio_for(code);
                range_sel = 3'(code);
                in_half   = 25.0 / rr;
                do_reset(1'b1);
                repeat (60) @(negedge clk_smp);
                watch(300, highs, rises);
                if (rc == rr || rc == 2 * rr) begin
                    check(highs == 0, $sformatf("R1 code %0d rate %0d quiet", code, rr),
                          highs, 0);
                end else if (rc >= 4 * rr) begin
                    check(rises >= 1, $sformatf("R1 code %0d rate %0d alarm", code, rr),
                          rises, 1);
                end
            end
        end

        // R6: hold request matched alarm throughout
        check(hold_mism == 0, "R6 hold equals alarm", hold_mism, 0);

        in_run = 1'b0;
        finish_run();
    end

endmodule